// File: doc/BRIEF.md
# Reconfigurable Two-Table Logic Slice

This block models one programmable logic slice built around a pair of 16-entry, 4-input lookup tables. A small mode field, loaded together with both truth tables, decides how the two tables are used. They can act as two independent 4-input functions, or be joined into one 5-input function where a select input picks between the two table outputs. They can also act as two 16x1 read-only tables, or as a 16x2 single-port memory that takes writes on the clock edge and reads asynchronously.

Truth tables and the mode are loaded through a serial shift port while the slice is held in its configuration state. A per-instance parameter marks the slice as unable to hold RAM. In such a slice the RAM code falls back to read-only behaviour, and the tables can change only through the shift port.

Top module: `config_slice`

## Requirements
- R1: On reset both tables and the mode field clear to zero. The mode is then the split logic code and `dout` reads 2'b00 for every address.
- R2: While `cfg_en` is high, every rising edge shifts `cfg_din` into a 34-bit chain and `dout` is held at 2'b00. After 34 shifts, the bits in the order sent are table A entries 0..15, then table B entries 0..15, then the mode code, low bit first.
- R3: Mode codes: 0 = split logic, 1 = 5-input logic, 2 = read-only, 3 = RAM.
- R4: In split logic mode, `dout[0]` is table A at `addr_a` and `dout[1]` is table B at `addr_b`, combinationally. `sel5` has no effect.
- R5: In 5-input mode both tables are indexed by `addr_a`. `dout[0]` is table B when `sel5` is 1 and table A when it is 0, and `dout[1]` is 0.
- R6: In read-only mode the outputs match split logic mode, and `we` has no effect on the tables.
- R7: In RAM mode (RAM_EN=1), a rising edge with `we` high and `cfg_en` low writes `wdata[0]` into table A and `wdata[1]` into table B at `addr_a`. `dout` is {B[addr_a], A[addr_a]}, read asynchronously, so it shows the old word until that edge.
- R8: In split logic and 5-input modes, `we` leaves the tables unchanged.
- R9: With RAM_EN=0, mode code 3 behaves as read-only: the outputs follow the read-only mapping and writes are ignored.
- R10: When `cfg_en` and `we` are high in the same cycle, the shift takes place and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; shifts and writes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Holds the slice in configuration state and enables shifting |
| cfg_din | input | 1 | Serial configuration bit |
| we | input | 1 | Write enable for RAM mode |
| wdata | input | 2 | Write word: bit 0 to table A, bit 1 to table B |
| addr_a | input | LUT_K | Address of table A; also the shared address in 5-input and RAM modes |
| addr_b | input | LUT_K | Address of table B in split logic and read-only modes |
| sel5 | input | 1 | Table select in 5-input mode |
| dout | output | 2 | Slice outputs |

## Verification
A configuration shift and a RAM write can be requested in the same cycle. The bench reloads an all-zero table image with RAM mode while holding `we` high, `wdata` at 2'b11 and `addr_a` at 0 through every shift cycle, including the last. It then reads address 0: any write that slipped past the shift, or landed after it, shows up as a 1 where 2'b00 is expected. A second case puts a write and an asynchronous read of the same word in one cycle. The old word is checked before the edge and the new word after it.

// File: rtl/slice_pkg.sv
package slice_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_SPLIT = 2'd0,
        MODE_LUT5  = 2'd1,
        MODE_ROM   = 2'd2,
        MODE_RAM   = 2'd3
    } slice_mode_e;
endpackage

// File: rtl/slice_lut_read.sv
module slice_lut_read #(
    parameter int LUT_K = 4,
    localparam int DEPTH = 1 << LUT_K
) (
    input  logic [DEPTH-1:0] table_bits,
    input  logic [LUT_K-1:0] addr,
    output logic             bit_out
);
    assign bit_out = table_bits[addr];
endmodule

// File: rtl/slice_cfg_store.sv
module slice_cfg_store
    import slice_pkg::*;
#(
    parameter int LUT_K  = 4,
    parameter bit RAM_EN = 1'b1,
    localparam int DEPTH = 1 << LUT_K
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic             we,
    input  logic [LUT_K-1:0] waddr,
    input  logic [1:0]       wdata,
    output logic [DEPTH-1:0] tab_a,
    output logic [DEPTH-1:0] tab_b,
    output slice_mode_e      mode
);
    localparam int CHAIN_W = 2 * DEPTH + MODE_W;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [DEPTH-1:0]  tab_b;
        logic [DEPTH-1:0]  tab_a;
    } store_t;

    store_t st_d, st_q;
    logic   wr_ok;

    assign wr_ok = RAM_EN && !cfg_en && we && (st_q.mode == MODE_RAM);

    always_comb begin
        st_d = st_q;
        if (cfg_en) begin
            st_d = {cfg_din, st_q[CHAIN_W-1:1]};
        end else if (wr_ok) begin
            st_d.tab_a[waddr] = wdata[0];
            st_d.tab_b[waddr] = wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tab_a = st_q.tab_a;
    assign tab_b = st_q.tab_b;
    assign mode  = slice_mode_e'(st_q.mode);

    // Mode changes only through the shift port
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(mode));

    // Logic modes never touch the tables
    assert_logic_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && (mode == MODE_SPLIT || mode == MODE_LUT5)) |=> ($stable(tab_a) && $stable(tab_b)));

    // Read-only mode never touches the tables
    assert_rom_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && mode == MODE_ROM) |=> ($stable(tab_a) && $stable(tab_b)));

    generate
        if (!RAM_EN) begin : g_no_ram
            // A slice without RAM changes its tables only while configuring
            assert_no_ram_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !cfg_en |=> ($stable(tab_a) && $stable(tab_b)));
        end
    endgenerate
endmodule

// File: rtl/config_slice.sv
module config_slice
    import slice_pkg::*;
#(
    parameter int LUT_K  = 4,
    parameter bit RAM_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic             we,
    input  logic [1:0]       wdata,
    input  logic [LUT_K-1:0] addr_a,
    input  logic [LUT_K-1:0] addr_b,
    input  logic             sel5,
    output logic [1:0]       dout
);
    localparam int DEPTH    = 1 << LUT_K;
    localparam int RD_PORTS = 3;

    logic [DEPTH-1:0]    tab_a, tab_b;
    slice_mode_e         mode;
    logic [DEPTH-1:0]    rd_tab  [RD_PORTS];
    logic [LUT_K-1:0]    rd_addr [RD_PORTS];
    logic [RD_PORTS-1:0] rd_bit;
    logic [1:0]          out_d;

    slice_cfg_store #(.LUT_K(LUT_K), .RAM_EN(RAM_EN)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_en (cfg_en),
        .cfg_din(cfg_din),
        .we     (we),
        .waddr  (addr_a),
        .wdata  (wdata),
        .tab_a  (tab_a),
        .tab_b  (tab_b),
        .mode   (mode)
    );

    // Read ports: 0 = A at addr_a, 1 = B at addr_a, 2 = B at addr_b
    assign rd_tab[0]  = tab_a;
    assign rd_addr[0] = addr_a;
    assign rd_tab[1]  = tab_b;
    assign rd_addr[1] = addr_a;
    assign rd_tab[2]  = tab_b;
    assign rd_addr[2] = addr_b;

    generate
        for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
            slice_lut_read #(.LUT_K(LUT_K)) u_rd (
                .table_bits(rd_tab[p]),
                .addr      (rd_addr[p]),
                .bit_out   (rd_bit[p])
            );
        end
    endgenerate

    always_comb begin
        out_d = 2'b00;
        if (!cfg_en) begin
            unique case (mode)
                MODE_SPLIT, MODE_ROM: out_d = {rd_bit[2], rd_bit[0]};
                MODE_LUT5:            out_d = {1'b0, sel5 ? rd_bit[1] : rd_bit[0]};
                MODE_RAM:             out_d = RAM_EN ? {rd_bit[1], rd_bit[0]}
                                                     : {rd_bit[2], rd_bit[0]};
                default:              out_d = 2'b00;
            endcase
        end
    end

    assign dout = out_d;

    // Outputs stay quiet while configuring
    assert_cfg_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (dout == 2'b00));

    // Upper output is unused in 5-input mode
    assert_lut5_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && mode == MODE_LUT5) |-> (dout[1] == 1'b0));

    generate
        if (RAM_EN) begin : g_ram_chk
            // A write is visible on the next cycle at the same address
            assert_ram_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg_en && we && mode == MODE_RAM) |=>
                    (!($stable(addr_a) && !cfg_en && mode == MODE_RAM) || dout == $past(wdata)));
        end
    endgenerate
endmodule

// File: tb/tb_config_slice.sv
`timescale 1ns/1ps
module tb_config_slice;
    localparam int LUT_K = 4;
    localparam logic [15:0] TA = 16'h6996;   // entry i = parity of i
    localparam logic [15:0] TB = 16'h8001;   // entries 0 and 15 set

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] a;
        logic [3:0] b;
        logic       sel;
        logic [1:0] exp;
    } vec_t;

    // Mode codes (R3): 0 split, 1 five-input, 2 read-only
    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        {2'd0, 4'd0,  4'd0,  1'b0, 2'b10},
        {2'd0, 4'd1,  4'd15, 1'b0, 2'b11},
        {2'd0, 4'd3,  4'd5,  1'b0, 2'b00},
        {2'd0, 4'd7,  4'd14, 1'b1, 2'b01},
        {2'd1, 4'd15, 4'd0,  1'b0, 2'b00},
        {2'd1, 4'd15, 4'd0,  1'b1, 2'b01},
        {2'd1, 4'd8,  4'd9,  1'b0, 2'b01},
        {2'd1, 4'd8,  4'd9,  1'b1, 2'b00},
        {2'd2, 4'd1,  4'd0,  1'b0, 2'b11},
        {2'd2, 4'd6,  4'd15, 1'b1, 2'b10}
    };

    logic clk = 1'b0;
    logic rst_n, cfg_en, cfg_din, we, sel5;
    logic [1:0] wdata;
    logic [LUT_K-1:0] addr_a, addr_b;
    logic [1:0] dout, dout_nr;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    config_slice #(.LUT_K(LUT_K), .RAM_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .we(we),
        .wdata(wdata), .addr_a(addr_a), .addr_b(addr_b), .sel5(sel5), .dout(dout));

    config_slice #(.LUT_K(LUT_K), .RAM_EN(1'b0)) dut_rom_only (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .we(we),
        .wdata(wdata), .addr_a(addr_a), .addr_b(addr_b), .sel5(sel5), .dout(dout_nr));

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] ta, input logic [15:0] tb, input logic [1:0] md);
        for (int i = 0; i < 34; i++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = (i < 16) ? ta[i] : (i < 32) ? tb[i-16] : md[i-32];
            if (i == 17) begin
                #1;
                check("R2 quiet while configuring", dout, 2'b00);
                check("R2 quiet while configuring (no RAM)", dout_nr, 2'b00);
            end
        end
        @(negedge clk);
        cfg_en  = 1'b0;
        cfg_din = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] cur_mode;
        rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0; we = 1'b0; sel5 = 1'b0;
        wdata = 2'b00; addr_a = 4'd1; addr_b = 4'd15;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset output", dout, 2'b00);
        check("R1 reset output (no RAM)", dout_nr, 2'b00);

        // Vector walk: R2 mapping, R3 codes, R4 split, R5 five-input, R6 read-only
        cur_mode = 2'd3;
        for (int v = 0; v < NV; v++) begin
            if (VEC[v].mode != cur_mode) begin
                load(TA, TB, VEC[v].mode);
                cur_mode = VEC[v].mode;
            end
            @(negedge clk);
            addr_a = VEC[v].a; addr_b = VEC[v].b; sel5 = VEC[v].sel;
            #1;
            case (VEC[v].mode)
                2'd0: check("R4 split lookup", dout, VEC[v].exp);
                2'd1: check("R5 five-input lookup", dout, VEC[v].exp);
                default: check("R6 read-only lookup", dout, VEC[v].exp);
            endcase
            check("R3 mode decode (no RAM)", dout_nr, VEC[v].exp);
        end

        // R6: write attempt in read-only mode
        @(negedge clk);
        addr_a = 4'd1; addr_b = 4'd0; we = 1'b1; wdata = 2'b00;
        @(negedge clk);
        we = 1'b0;
        #1;
        check("R6 write ignored in read-only", dout, 2'b11);

        // R8: write attempt in split logic mode
        load(TA, TB, 2'd0);
        @(negedge clk);
        addr_a = 4'd7; addr_b = 4'd15; we = 1'b1; wdata = 2'b00;
        @(negedge clk);
        we = 1'b0;
        #1;
        check("R8 write ignored in split logic", dout, 2'b11);

        // R7 / R9: RAM mode
        load(TA, TB, 2'd3);
        @(negedge clk);
        addr_a = 4'd5; addr_b = 4'd3; we = 1'b1; wdata = 2'b10;
        #1;
        check("R7 old word before write edge", dout, 2'b00);
        @(negedge clk);
        we = 1'b0;
        #1;
        check("R7 word after write", dout, 2'b10);
        check("R9 no-RAM slice reads as read-only", dout_nr, 2'b00);
        @(negedge clk);
        addr_a = 4'd0; we = 1'b1; wdata = 2'b11;
        #1;
        check("R7 old word at address 0", dout, 2'b10);
        @(negedge clk);
        we = 1'b0;
        #1;
        check("R7 second write", dout, 2'b11);
        check("R9 no-RAM slice ignores write", dout_nr, 2'b00);
        @(negedge clk);
        addr_a = 4'd5;
        #1;
        check("R7 first write retained", dout, 2'b10);

        // R10: write requested on every shift cycle of a reload
        @(negedge clk);
        addr_a = 4'd0; addr_b = 4'd0; we = 1'b1; wdata = 2'b11;
        load(16'h0000, 16'h0000, 2'd3);
        we = 1'b0;
        #1;
        check("R10 shift wins over write", dout, 2'b00);
        check("R10 shift wins over write (no RAM)", dout_nr, 2'b00);

        // R1: reset in mid-run clears contents
        load(TA, TB, 2'd0);
        @(negedge clk);
        addr_a = 4'd1; addr_b = 4'd0;
        #1;
        check("R4 reloaded before reset", dout, 2'b11);
        rst_n = 1'b0;
        #1;
        check("R1 reset clears tables", dout, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 cleared after release", dout, 2'b00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule